// File: doc/BRIEF.md
# Banked 24-bit Address Decoder

This block turns a 24-bit processor address into five active-low chip selects: one for RAM, one for ROM, two for versatile interface adapters (VIA) and one for a serial communications adapter (ACIA). The processor drives only the low 16 address bits on dedicated pins. It presents the top 8 bits, the bank byte, on the data bus during clock phase 1. The block captures that byte while phase 2 is low and holds it through phase 2. It then decodes the joined bank and low address into the memory map.

The bank capture runs on a fast system clock. While phase 2 is low, the stored bank follows the data bus on every system clock edge. While phase 2 is high, the stored bank is frozen. Clock-phase qualification differs by target. RAM is enabled only while phase 2 is high. ROM is not gated, so it gets the whole cycle to respond. The peripheral selects are not gated either, so they are valid before phase 2 rises.

Top module: `bank_addr_decoder`

## Requirements
- R1: While `phi2` is low, each rising edge of `clk` loads `data_i` into `bank_o`; the stored bank equals the data byte present at the most recent such edge.
- R2: While `phi2` is high, `bank_o` holds its value whatever `data_i` does.
- R3: For full addresses 0x000100 to 0x01FFFF, `ram_sel_n` is low only while `phi2` is high; it is high whenever `phi2` is low.
- R4: For full addresses 0x020000 to 0x03FFFF, `rom_sel_n` is low in both clock phases.
- R5: For full addresses 0x000000 to 0x00000F (bits 23..4 all zero), `via0_sel_n` is low in both phases.
- R6: For full addresses 0x000010 to 0x00001F (bit 4 set, bits 23..5 zero), `via1_sel_n` is low in both phases.
- R7: For full addresses 0x000020 to 0x00003F (bit 5 set, bits 23..6 zero), `acia_sel_n` is low in both phases.
- R8: Full addresses 0x000040 to 0x0000FF, and every address from 0x040000 upward, drive all five selects high.
- R9: At most one select is low at any time.
- R10: While `rst_n` is low, `bank_o` is 0x00.

The full address is `{bank_o, addr_i}`, and all selects are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the processor phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock level |
| addr_i | input | 16 | Low 16 address bits |
| data_i | input | 8 | Data bus; carries the bank byte during phase 1 |
| bank_o | output | 8 | Captured bank byte (address bits 23..16) |
| ram_sel_n | output | 1 | RAM select, qualified by phase 2 |
| rom_sel_n | output | 1 | ROM select, not phase-qualified |
| via0_sel_n | output | 1 | First VIA select |
| via1_sel_n | output | 1 | Second VIA select |
| acia_sel_n | output | 1 | Serial adapter select |

## Verification
The hardest case to produce at the ports is a data bus that changes during phase 2 while the low address points into a region that only a different bank would select. That is what shows that decoding uses the held bank and not the live bus. In every vector the bench drives the inverted bank byte onto the data bus as soon as `phi2` rises. Several low addresses are also reused across banks, such as 0x0020 with bank 0x01 and 0x0010 with bank 0x02. A wrongly open capture path then moves the select to another target, and the check catches it.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    // Ungated region hits, one flag per target.
    typedef struct packed {
        logic ram;
        logic rom;
        logic via0;
        logic via1;
        logic acia;
    } region_hit_t;

    localparam int unsigned NUM_TARGETS = 5;

endpackage

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int unsigned BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_o
);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // The capture is open through phase 1 and closed through phase 2.
    always_comb begin
        st_d = st_q;
        if (!phi2) begin
            st_d.bank = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_o = st_q.bank;

    assert_capture_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |=> bank_o == $past(data_i));

    assert_hold_in_phase2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |=> $stable(bank_o));

endmodule

// File: rtl/region_decode.sv
module region_decode
    import addr_dec_pkg::*;
#(
    parameter int unsigned LO_W      = 16,
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned IO_LAST   = 32'h0000_00FF,
    parameter int unsigned RAM_LAST  = 32'h0001_FFFF,
    parameter int unsigned ROM_LAST  = 32'h0003_FFFF,
    parameter int unsigned VIA_SHIFT = 4
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [LO_W-1:0]   addr_i,
    output region_hit_t       hit_o
);

    localparam int unsigned FULL_W = LO_W + BANK_W;
    localparam logic [FULL_W-1:0] IO_LAST_W  = FULL_W'(IO_LAST);
    localparam logic [FULL_W-1:0] RAM_LAST_W = FULL_W'(RAM_LAST);
    localparam logic [FULL_W-1:0] ROM_LAST_W = FULL_W'(ROM_LAST);
    localparam logic [FULL_W-1:0] ONE_W      = FULL_W'(1);

    logic [FULL_W-1:0] full;

    always_comb begin
        full        = {bank_i, addr_i};
        hit_o.ram   = (full > IO_LAST_W)  && (full <= RAM_LAST_W);
        hit_o.rom   = (full > RAM_LAST_W) && (full <= ROM_LAST_W);
        hit_o.via0  = (full >> VIA_SHIFT) == '0;
        hit_o.via1  = (full >> VIA_SHIFT) == ONE_W;
        hit_o.acia  = (full >> (VIA_SHIFT + 1)) == ONE_W;
    end

endmodule

// File: rtl/phase_gate.sv
module phase_gate
    import addr_dec_pkg::*;
(
    input  logic        phi2,
    input  region_hit_t hit_i,
    output logic        ram_sel_n,
    output logic        rom_sel_n,
    output logic        via0_sel_n,
    output logic        via1_sel_n,
    output logic        acia_sel_n
);

    // Only RAM waits for phase 2; all other targets see the raw decode.
    always_comb begin
        ram_sel_n  = ~(hit_i.ram & phi2);
        rom_sel_n  = ~hit_i.rom;
        via0_sel_n = ~hit_i.via0;
        via1_sel_n = ~hit_i.via1;
        acia_sel_n = ~hit_i.acia;
    end

endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
    import addr_dec_pkg::*;
#(
    parameter int unsigned LO_W      = 16,
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned IO_LAST   = 32'h0000_00FF,
    parameter int unsigned RAM_LAST  = 32'h0001_FFFF,
    parameter int unsigned ROM_LAST  = 32'h0003_FFFF,
    parameter int unsigned VIA_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [LO_W-1:0]   addr_i,
    input  logic [BANK_W-1:0] data_i,
    output logic [BANK_W-1:0] bank_o,
    output logic              ram_sel_n,
    output logic              rom_sel_n,
    output logic              via0_sel_n,
    output logic              via1_sel_n,
    output logic              acia_sel_n
);

    localparam int unsigned FULL_W = LO_W + BANK_W;
    localparam logic [FULL_W-1:0] IO_LAST_W  = FULL_W'(IO_LAST);
    localparam logic [FULL_W-1:0] RAM_LAST_W = FULL_W'(RAM_LAST);
    localparam logic [FULL_W-1:0] ROM_LAST_W = FULL_W'(ROM_LAST);
    localparam logic [FULL_W-1:0] PERIPH_END = FULL_W'(1) << (VIA_SHIFT + 2);

    region_hit_t hit;

    bank_latch #(.BANK_W(BANK_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi2   (phi2),
        .data_i (data_i),
        .bank_o (bank_o)
    );

    region_decode #(
        .LO_W      (LO_W),
        .BANK_W    (BANK_W),
        .IO_LAST   (IO_LAST),
        .RAM_LAST  (RAM_LAST),
        .ROM_LAST  (ROM_LAST),
        .VIA_SHIFT (VIA_SHIFT)
    ) u_decode (
        .bank_i (bank_o),
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    phase_gate u_gate (
        .phi2       (phi2),
        .hit_i      (hit),
        .ram_sel_n  (ram_sel_n),
        .rom_sel_n  (rom_sel_n),
        .via0_sel_n (via0_sel_n),
        .via1_sel_n (via1_sel_n),
        .acia_sel_n (acia_sel_n)
    );

    logic [FULL_W-1:0] full_addr;
    assign full_addr = {bank_o, addr_i};

    assert_ram_only_phase2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> ram_sel_n);

    assert_ram_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> (full_addr > IO_LAST_W) && (full_addr <= RAM_LAST_W));

    assert_rom_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel_n |-> (full_addr > RAM_LAST_W) && (full_addr <= ROM_LAST_W));

    assert_periph_low_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(via0_sel_n && via1_sel_n && acia_sel_n) |-> full_addr < PERIPH_END);

    assert_no_select_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_addr > ROM_LAST_W) |->
            (ram_sel_n && rom_sel_n && via0_sel_n && via1_sel_n && acia_sel_n));

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{ram_sel_n, rom_sel_n, via0_sel_n, via1_sel_n, acia_sel_n}));

endmodule

// File: tb/bank_addr_decoder_bench.sv
module bank_addr_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = 8'hA5;
    logic [7:0]  bank;
    logic        ram_n, rom_n, via0_n, via1_n, acia_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bank_addr_decoder u_bank_addr_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi2       (phi2),
        .addr_i     (addr),
        .data_i     (data),
        .bank_o     (bank),
        .ram_sel_n  (ram_n),
        .rom_sel_n  (rom_n),
        .via0_sel_n (via0_n),
        .via1_sel_n (via1_n),
        .acia_sel_n (acia_n)
    );

    // Active-high code order: {ram, rom, via0, via1, acia}
    localparam logic [4:0] S_NONE = 5'b00000;
    localparam logic [4:0] S_RAM  = 5'b10000;
    localparam logic [4:0] S_ROM  = 5'b01000;
    localparam logic [4:0] S_V0   = 5'b00100;
    localparam logic [4:0] S_V1   = 5'b00010;
    localparam logic [4:0] S_AC   = 5'b00001;

    localparam int NVEC = 22;
    // {full address (24), expected phase-2 select code (5)}
    localparam logic [28:0] VEC [NVEC] = '{
        {24'h000000, S_V0},   // R5
        {24'h00000F, S_V0},   // R5
        {24'h000010, S_V1},   // R6
        {24'h00001F, S_V1},   // R6
        {24'h000020, S_AC},   // R7
        {24'h00003F, S_AC},   // R7
        {24'h000040, S_NONE}, // R8
        {24'h0000FF, S_NONE}, // R8
        {24'h000100, S_RAM},  // R3
        {24'h000200, S_RAM},  // R3
        {24'h00FFFF, S_RAM},  // R3
        {24'h010000, S_RAM},  // R3
        {24'h010020, S_RAM},  // R3 low half matches acia
        {24'h01FFFF, S_RAM},  // R3
        {24'h020000, S_ROM},  // R4
        {24'h020010, S_ROM},  // R4 low half matches via1
        {24'h03FFFF, S_ROM},  // R4
        {24'h040000, S_NONE}, // R8
        {24'h040005, S_NONE}, // R8
        {24'h800000, S_NONE}, // R8
        {24'hFFFFFF, S_NONE}, // R8
        {24'h0300FF, S_ROM}   // R4
    };

    function automatic logic [4:0] sel_code();
        return ~{ram_n, rom_n, via0_n, via1_n, acia_n};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check5(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // R10: reset holds bank at zero even with data present in phase 1
        repeat (3) @(negedge clk);
        #1 check8("R10 bank in reset", bank, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: phase 1 then phase 2 with bus scrambled
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] fa;
            logic [4:0]  ex;
            fa = VEC[i][28:5];
            ex = VEC[i][4:0];
            @(negedge clk);
            phi2 = 1'b0;
            data = fa[23:16];
            addr = fa[15:0];
            @(negedge clk);
            #1;
            check8("R1 bank captured", bank, fa[23:16]);
            check5("R3 phase1 selects (ram held off)", sel_code(), ex & ~S_RAM);
            phi2 = 1'b1;
            data = ~fa[23:16];
            @(negedge clk);
            #1;
            check8("R2 bank held in phase2", bank, fa[23:16]);
            check5("R9 phase2 selects", sel_code(), ex);
        end

        // R1: bank follows the last byte seen during phase 1
        @(negedge clk);
        phi2 = 1'b0;
        data = 8'h11;
        addr = 16'h0000;
        @(negedge clk);
        data = 8'h02;
        @(negedge clk);
        #1 check8("R1 last phase1 byte", bank, 8'h02);
        check5("R4 rom select in phase1", sel_code(), S_ROM);

        // R2: several bus changes across a long phase 2
        phi2 = 1'b1;
        data = 8'h00;
        @(negedge clk);
        data = 8'h7F;
        @(negedge clk);
        #1 check8("R2 long phase2 hold", bank, 8'h02);
        check5("R4 rom select in phase2", sel_code(), S_ROM);

        // R3: RAM select drops when phase 2 falls
        @(negedge clk);
        phi2 = 1'b0;
        data = 8'h01;
        addr = 16'h2345;
        @(negedge clk);
        #1 check5("R3 ram off in phase1", sel_code(), S_NONE);
        phi2 = 1'b1;
        #1 check5("R3 ram on with phase2", sel_code(), S_RAM);

        // R10: reset mid-run clears bank
        @(negedge clk);
        rst_n = 1'b0;
        #1 check8("R10 async reset", bank, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        finish_run();
    end

endmodule